// File: doc/BRIEF.md
# Pulse-Per-Second Period Monitor

This block timestamps an external once-per-second timing pulse against a free-running 32-bit tick counter. That counter is shared with the chip's trigger timestamping logic, so a pulse stamp and a trigger stamp can be subtracted directly. The asynchronous pulse first passes through a configurable flop synchroniser and a rising-edge detector. In the cycle the edge is detected, the current counter value is captured. The tick distance from the previous capture is then computed modulo 2^32 and tested against a nominal period with a symmetric tolerance band.

A host reads the captured stamp, the measured period and a 4-bit status word. The status word has fixed bit positions, because downstream software decodes them:

| Bit | Meaning |
|-----|---------|
| 0 | A pulse was captured and has not yet been acknowledged. |
| 1 | Registered copy of the trigger-pending input, meaning timestamp data is waiting. |
| 2 | Always 0. |
| 3 | The current or most recent period is out of band. |

A stamp of zero means no pulse has arrived since reset.

There is no stream interface and no back-pressure. The host never stalls a capture. A new pulse overwrites the stamp and the period whether or not the previous one was acknowledged. The pending bit plus the acknowledge strobe are the only flow control.

Top module: `pps_period_monitor`

## Requirements
- R1: After reset, `pps_count_o`, `period_o` and `status_o` are all zero, and a zero stamp marks that no pulse has been captured yet.
- R2: The synchroniser has SYNC_STAGES flops (default 2). `pps_count_o` takes the value of `tick_cnt_i` present at the (SYNC_STAGES+1)-th rising clock edge, counting from the first edge that samples `pps_i` high. The new value is visible after that edge.
- R3: The first capture after reset only loads the reference stamp. `period_o` stays 0 and `status_o[3]` stays 0.
- R4: On every later capture, `period_o` becomes (new stamp − previous stamp) mod 2^32.
- R5: On every later capture, `status_o[3]` becomes 1 if the period is above NOMINAL+TOL or below NOMINAL−TOL, and 0 otherwise. A period exactly at either limit counts as good.
- R6: While armed and with no pulse arriving, `status_o[3]` is set one cycle after (`tick_cnt_i` − last stamp) mod 2^32 exceeds NOMINAL+TOL.
- R7: `status_o[0]` is set by every capture and stays set until acknowledged.
- R8: A one-cycle `ack_i` clears `status_o[0]` on the following cycle. If a capture happens in the same cycle as `ack_i`, the bit stays set.
- R9: `status_o[1]` equals `trig_pending_i` delayed by one cycle, and `status_o[2]` is always 0.
- R10: A counter wrap between two pulses that are NOMINAL ticks apart reports `period_o` = NOMINAL and `status_o[3]` = 0.
- R11: Holding `pps_i` high causes exactly one capture. A new capture needs `pps_i` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | Asynchronous once-per-second pulse |
| tick_cnt_i | input | CNT_W | Free-running tick counter shared with trigger timestamps |
| ack_i | input | 1 | One-cycle host acknowledge of the pending pulse |
| trig_pending_i | input | 1 | Trigger timestamp data waiting to be read |
| pps_count_o | output | CNT_W | Counter value captured at the last pulse |
| period_o | output | CNT_W | Ticks between the last two captures |
| status_o | output | 4 | Status bits as listed above |

## Verification
The assertions assume three things about the inputs: `tick_cnt_i` moves forward between captures, `ack_i` is a single-cycle strobe, and each pulse high or low phase lasts longer than the synchroniser depth, so every rising edge produces one detection.

The stimulus drives all inputs on the falling clock edge and places each pulse by setting the counter two ticks short of the target stamp. It holds every pulse high for several cycles and low for at least four cycles. Random periods are drawn from a window 100 ticks either side of nominal, so both in-band and out-of-band intervals occur. Directed cases cover the exact band limits, the overdue check, the counter wrap and an acknowledge that coincides with a capture.

// File: rtl/pps_mon_pkg.sv
package pps_mon_pkg;

  // Status word bit positions; host software decodes these positions.
  localparam int ST_PEND_BIT = 0;
  localparam int ST_TRIG_BIT = 1;
  localparam int ST_RSVD_BIT = 2;
  localparam int ST_BAD_BIT  = 3;
  localparam int ST_W        = 4;

  typedef struct packed {
    logic period_bad;   // bit 3
    logic reserved;     // bit 2
    logic trig_wait;    // bit 1
    logic pulse_pend;   // bit 0
  } pps_status_t;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_async,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // Synchroniser chain; the stage count is a parameter.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= pulse_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  // Registered copy of the synchronised level, used for edge detection.
  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pps_interval_check.sv
module pps_interval_check #(
  parameter int          CNT_W   = 32,
  parameter int unsigned NOMINAL = 41666666,
  parameter int unsigned TOL     = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tick_i,
  input  logic             capture_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] stamp_o,
  output logic [CNT_W-1:0] period_o,
  output logic             bad_o
);

  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(NOMINAL + TOL);
  localparam logic [CNT_W-1:0] LO_LIM = (TOL > NOMINAL) ? '0 : CNT_W'(NOMINAL - TOL);

  logic [CNT_W-1:0] stamp_q, period_q, elapsed;
  logic             armed_q, bad_q, out_band, overdue;

  // One subtractor serves both the capture evaluation and the overdue watch.
  assign elapsed  = tick_i - stamp_q;
  assign out_band = (elapsed > HI_LIM) || (elapsed < LO_LIM);
  assign overdue  = armed_q && (elapsed > HI_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q  <= '0;
      period_q <= '0;
      armed_q  <= 1'b0;
      bad_q    <= 1'b0;
    end else if (capture_i) begin
      stamp_q <= tick_i;
      armed_q <= 1'b1;
      if (armed_q) begin
        period_q <= elapsed;
        bad_q    <= out_band;
      end
    end else if (overdue) begin
      bad_q <= 1'b1;
    end
  end

  assign armed_o  = armed_q;
  assign stamp_o  = stamp_q;
  assign period_o = period_q;
  assign bad_o    = bad_q;

endmodule

// File: rtl/pps_pend_flag.sv
module pps_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);

  logic flag_q;

  // A capture wins over a simultaneous acknowledge.
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pps_period_monitor.sv
module pps_period_monitor
  import pps_mon_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int unsigned NOMINAL     = 41666666,
  parameter int unsigned TOL         = 50,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_i,
  input  logic [CNT_W-1:0] tick_cnt_i,
  input  logic             ack_i,
  input  logic             trig_pending_i,
  output logic [CNT_W-1:0] pps_count_o,
  output logic [CNT_W-1:0] period_o,
  output logic [ST_W-1:0]  status_o
);

  logic        latch_evt;
  logic        armed;
  logic        bad;
  logic        pend;
  logic        trig_q;
  pps_status_t status;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_async (pps_i),
    .rise_o      (latch_evt)
  );

  pps_interval_check #(
    .CNT_W   (CNT_W),
    .NOMINAL (NOMINAL),
    .TOL     (TOL)
  ) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_cnt_i),
    .capture_i (latch_evt),
    .armed_o   (armed),
    .stamp_o   (pps_count_o),
    .period_o  (period_o),
    .bad_o     (bad)
  );

  pps_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (latch_evt),
    .ack_i  (ack_i),
    .flag_o (pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_pending_i;
  end

  always_comb begin
    status            = '0;
    status.pulse_pend = pend;
    status.trig_wait  = trig_q;
    status.reserved   = 1'b0;
    status.period_bad = bad;
  end

  assign status_o = status;

endmodule

// File: rtl/pps_period_monitor_chk.sv
module pps_period_monitor_chk #(
  parameter int          CNT_W   = 32,
  parameter int unsigned NOMINAL = 41666666,
  parameter int unsigned TOL     = 50
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tick_cnt_i,
  input logic             ack_i,
  input logic             trig_pending_i,
  input logic [CNT_W-1:0] pps_count_o,
  input logic [CNT_W-1:0] period_o,
  input logic [3:0]       status_o,
  input logic             latch_evt,
  input logic             armed
);

  localparam logic [CNT_W-1:0] HI = CNT_W'(NOMINAL + TOL);
  localparam logic [CNT_W-1:0] LO = (TOL > NOMINAL) ? '0 : CNT_W'(NOMINAL - TOL);

  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> pps_count_o == $past(tick_cnt_i));

  a_r2_stamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(pps_count_o));

  a_r3_first_no_period: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && !armed) |=> (period_o == $past(period_o)));

  a_r4_period_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && armed) |=> period_o == $past(tick_cnt_i - pps_count_o));

  a_r5_band_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && armed) |=> status_o[3] == ((period_o > HI) || (period_o < LO)));

  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> status_o[0]);

  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !ack_i) |=> status_o[0]);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !latch_evt) |=> !status_o[0]);

  a_r9_trig_copy: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_o[1] == $past(trig_pending_i));

  a_r11_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !latch_evt);

endmodule

bind pps_period_monitor pps_period_monitor_chk #(
  .CNT_W   (CNT_W),
  .NOMINAL (NOMINAL),
  .TOL     (TOL)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_cnt_i     (tick_cnt_i),
  .ack_i          (ack_i),
  .trig_pending_i (trig_pending_i),
  .pps_count_o    (pps_count_o),
  .period_o       (period_o),
  .status_o       (status_o),
  .latch_evt      (latch_evt),
  .armed          (armed)
);

// File: tb/pps_period_monitor_tb.sv
module pps_period_monitor_tb;

  localparam int          W   = 32;
  localparam int unsigned NOM = 1000;
  localparam int unsigned TL  = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pps_i = 1'b0;
  logic [W-1:0]  tick_cnt_i = '0;
  logic          ack_i = 1'b0;
  logic          trig_pending_i = 1'b0;
  logic [W-1:0]  pps_count_o, period_o;
  logic [3:0]    status_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [W-1:0] last_at;
  logic         exp_bad;

  always #5 clk = ~clk;

  pps_period_monitor #(.CNT_W(W), .NOMINAL(NOM), .TOL(TL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .tick_cnt_i(tick_cnt_i),
    .ack_i(ack_i), .trig_pending_i(trig_pending_i),
    .pps_count_o(pps_count_o), .period_o(period_o), .status_o(status_o)
  );

  function automatic logic band_bad(input logic [W-1:0] p);
    return (p > W'(NOM + TL)) || (p < W'(NOM - TL));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Places a capture at stamp value 'at'; optionally pulses ack in the capture cycle.
  task automatic do_pulse(input logic [W-1:0] at, input bit ack_same, input int hold);
    @(negedge clk); tick_cnt_i = at - 2; pps_i = 1'b1;
    @(negedge clk); tick_cnt_i = at - 1;
    @(negedge clk); tick_cnt_i = at; ack_i = ack_same;
    @(negedge clk); ack_i = 1'b0;
    chk("R2 stamp", pps_count_o, at);
    chk("R7 pending set", W'(status_o[0]), 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); tick_cnt_i = tick_cnt_i + 1;
    end
    @(negedge clk); pps_i = 1'b0; tick_cnt_i = tick_cnt_i + 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tick_cnt_i = tick_cnt_i + 1;
    end
  endtask

  task automatic pulse_checked(input logic [W-1:0] at, input string tag);
    logic [W-1:0] p;
    p = at - last_at;
    do_pulse(at, 1'b0, 2);
    chk({tag, " period"}, period_o, p);
    chk({tag, " band"}, W'(status_o[3]), W'(band_bad(p)));
    last_at = at;
  endtask

  task automatic ack_now();
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    chk("R8 ack clears", W'(status_o[0]), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset stamp", pps_count_o, 0);
    chk("R1 reset period", period_o, 0);
    chk("R1 reset status", W'(status_o), 0);

    // R9: trigger-pending mirror, one cycle late
    trig_pending_i = 1'b1;
    @(negedge clk);
    chk("R9 trig bit", W'(status_o[1]), 1);
    chk("R9 reserved bit", W'(status_o[2]), 0);
    trig_pending_i = 1'b0;
    @(negedge clk);
    chk("R9 trig bit low", W'(status_o[1]), 0);

    // R3: first capture only loads the reference
    do_pulse(32'd5000, 1'b0, 10);
    chk("R11 held high no recapture", pps_count_o, 32'd5000);
    chk("R3 no period", period_o, 0);
    chk("R3 no flag", W'(status_o[3]), 0);
    chk("R7 pending holds", W'(status_o[0]), 1);
    last_at = 32'd5000;
    ack_now();

    // R4/R5 boundaries
    pulse_checked(last_at + NOM,          "R4 nominal");
    pulse_checked(last_at + NOM + TL,     "R5 upper limit");
    pulse_checked(last_at + NOM + TL + 1, "R5 above limit");
    pulse_checked(last_at + NOM - TL,     "R5 lower limit");
    pulse_checked(last_at + NOM - TL - 1, "R5 below limit");
    pulse_checked(last_at + NOM,          "R5 recover");

    // R8: ack coinciding with a capture keeps pending
    ack_now();
    do_pulse(last_at + NOM, 1'b1, 2);
    last_at = last_at + NOM;
    chk("R8 ack with capture keeps pending", W'(status_o[0]), 1);
    ack_now();

    // R6: overdue detection with no pulse
    @(negedge clk); tick_cnt_i = last_at + NOM + TL;
    @(negedge clk);
    chk("R6 at limit not overdue", W'(status_o[3]), 0);
    tick_cnt_i = last_at + NOM + TL + 1;
    @(negedge clk);
    chk("R6 overdue flag", W'(status_o[3]), 1);
    chk("R6 no capture", pps_count_o, last_at);
    pulse_checked(last_at + 3 * NOM, "R6 late pulse");
    pulse_checked(last_at + NOM,     "R6 clear");

    // R10: counter wrap
    pulse_checked(32'hFFFF_FE00, "R10 pre-wrap");
    pulse_checked(32'hFFFF_FE00 + NOM, "R10 wrap");

    // Random periods around nominal
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] per;
      per = W'(NOM - 100) + W'($urandom_range(0, 200));
      pulse_checked(last_at + per, "R5 random");
      if ($urandom_range(0, 1) == 1) ack_now();
      else begin
        @(negedge clk);
        chk("R7 random pending", W'(status_o[0]), 1);
      end
    end

    finish_run();
  end

endmodule